// File: doc/BRIEF.md
# Peripheral Interrupt Status Aggregator

This block gathers the interrupt sources of a USB-style peripheral controller into two 8-bit status registers. A local CPU reaches them, and two matching enable registers, over a small register port with a 2-bit address, 8-bit write data, a write strobe and combinational read data. Event sources arrive as single-cycle pulses: start-of-frame, six general events and a host suspend request. The four endpoint pending flags arrive as levels. Each event flag latches in its status bit and stays set until the CPU writes a 1 to that bit. The endpoint bits show the live input level and cannot be written.

The block drives one registered interrupt line. That line goes high when any status bit is set and its enable bit is also set. The block also drives a suspend-entry pulse. The CPU raises that pulse when it acknowledges the suspend flag. Status bits latch whatever the enable bits hold, so software can poll them as well as take interrupts.

Top module: `irq_status_hub`

## Requirements
- R1: After a synchronous active-low reset, all four registers read 0x00, and irq_out and suspend_enter are low.
- R2: Offset 0 bits 3:0 read the live ep_pending[3:0] level. Bit 0 is endpoint 0 and bits 1..3 are endpoints A, B and C. Writes to these bits have no effect.
- R3: Offset 0 bit 7 sets on sof_pulse and clears when a 1 is written to it.
- R4: Offset 0 bits 6:5 latch evt0_pulse[1:0]. Offset 1 bits 2:1 latch evt1_pulse[1:0] and offset 1 bits 7:4 latch evt1_pulse[5:2]. Writing a 1 clears a bit; writing a 0 leaves it as it is.
- R5: Offset 1 bit 3 latches suspend_req. A write to offset 1 with data bit 3 set clears the flag and raises suspend_enter for exactly the one cycle after that write edge.
- R6: A status bit latches its event even when its enable bit is 0.
- R7: Offset 0 bit 4 and offset 1 bit 0 always read 0 and ignore writes.
- R8: When an event pulse and a write-1 clear of the same bit fall in the same cycle, the bit ends up 1.
- R9: The enable registers at offsets 2 and 3 are plain 8-bit read/write registers.
- R10: irq_out is registered. In each cycle it equals whether, in the cycle before, any status bit AND its enable bit was 1 (offset 0 with offset 2, offset 1 with offset 3).
- R11: Offsets 0..3 select status 0, status 1, enable 0 and enable 1. reg_rdata follows reg_addr within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Combinational read data |
| sof_pulse | input | 1 | Start-of-frame received |
| evt0_pulse | input | 2 | Events for status 0 bits 6:5 |
| evt1_pulse | input | 6 | Events for status 1 bits 2:1 and 7:4 |
| suspend_req | input | 1 | Host suspend request |
| ep_pending | input | 4 | Endpoint pending levels |
| irq_out | output | 1 | Local interrupt |
| suspend_enter | output | 1 | Suspend-entry pulse |

## Verification
A wrong flag bit shows up on reg_rdata in the cycle right after the edge that should have set or cleared it. It also shows on irq_out one edge later, provided the bit is enabled. A broken clear path, a lost set-over-clear priority or a mis-routed event lane makes the read value differ from the bench model at the next read of that offset. A suspend pulse that is missing, stretched or spurious is caught at the one edge following each write to offset 1.

// File: rtl/ish_pkg.sv
// Shared constants for the interrupt status aggregator.
// Assumes an 8-bit register port and four register offsets.
package ish_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int EP_N     = 4;
    localparam int EVT0_N   = 2;
    localparam int EVT1_N   = 6;

    localparam logic [ADDR_W-1:0] OFS_STAT0 = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_STAT1 = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_EN0   = 2'd2;
    localparam logic [ADDR_W-1:0] OFS_EN1   = 2'd3;

    // Bits that hold latched write-1-to-clear flags
    localparam logic [DATA_W-1:0] LATCH_MASK0 = 8'hE0;
    localparam logic [DATA_W-1:0] LATCH_MASK1 = 8'hFE;

    localparam int SOF_BIT  = 7;
    localparam int SUSP_BIT = 3;
endpackage

// File: rtl/ish_w1c_bank.sv
// Bank of sticky event flags. Set has priority over a write-1 clear.
// Bits outside MASK are tied to zero. Assumes set_i and clr_i are
// single-cycle qualified vectors.
module ish_w1c_bank #(
    parameter int                 WIDTH = 8,
    parameter logic [WIDTH-1:0]   MASK  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (MASK[i]) begin : g_flag
            // Latch event, clear on write-1, event wins a tie
            always_ff @(posedge clk) begin
                if (!rst_n)        q[i] <= 1'b0;
                else if (set_i[i]) q[i] <= 1'b1;
                else if (clr_i[i]) q[i] <= 1'b0;
            end

            p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[i] |=> q[i]);
            p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !set_i[i]) |=> !q[i]);
            p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_i[i] && !set_i[i]) |=> $stable(q[i]));
        end else begin : g_tie
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/ish_rw_reg.sv
// Plain read/write register with synchronous reset to zero.
module ish_rw_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    // Load on write strobe
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end

    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(wdata)));
endmodule

// File: rtl/ish_irq_combine.sv
// Masks two status views with their enables and registers the OR.
// Assumes both views are already fully assembled.
module ish_irq_combine #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] stat0,
    input  logic [WIDTH-1:0] stat1,
    input  logic [WIDTH-1:0] en0,
    input  logic [WIDTH-1:0] en1,
    output logic             irq
);
    logic hit;

    // Any enabled status bit
    always_comb hit = |(stat0 & en0) || |(stat1 & en1);

    // Register the interrupt line
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= hit;
    end

    p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat0 & en0)) |=> irq);
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|(stat0 & en0)) && !(|(stat1 & en1))) |=> !irq);
endmodule

// File: rtl/irq_status_hub.sv
// Interrupt status aggregator top. It decodes the register port, builds
// the two status views, holds the enables, and drives the interrupt
// and the suspend-entry pulse. Assumes the event inputs are synchronous
// single-cycle pulses.
module irq_status_hub
    import ish_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic                reg_we,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                sof_pulse,
    input  logic [EVT0_N-1:0]   evt0_pulse,
    input  logic [EVT1_N-1:0]   evt1_pulse,
    input  logic                suspend_req,
    input  logic [EP_N-1:0]     ep_pending,
    output logic                irq_out,
    output logic                suspend_enter
);
    logic [DATA_W-1:0] set0, set1, clr0, clr1;
    logic [DATA_W-1:0] flags0, flags1, view0, en0_q, en1_q;
    logic              wr0, wr1, wr2, wr3;
    logic              susp_q;

    // Address decode of write strobes
    always_comb begin
        wr0 = reg_we && (reg_addr == OFS_STAT0);
        wr1 = reg_we && (reg_addr == OFS_STAT1);
        wr2 = reg_we && (reg_addr == OFS_EN0);
        wr3 = reg_we && (reg_addr == OFS_EN1);
    end

    // Route event pulses to their flag positions
    always_comb begin
        set0 = '0;
        set0[SOF_BIT]  = sof_pulse;
        set0[6:5]      = evt0_pulse;
        set1 = '0;
        set1[2:1]      = evt1_pulse[1:0];
        set1[SUSP_BIT] = suspend_req;
        set1[7:4]      = evt1_pulse[5:2];
        clr0 = wr0 ? reg_wdata : '0;
        clr1 = wr1 ? reg_wdata : '0;
    end

    ish_w1c_bank #(.WIDTH(DATA_W), .MASK(LATCH_MASK0)) u_flags0 (
        .clk(clk), .rst_n(rst_n), .set_i(set0), .clr_i(clr0), .q(flags0));

    ish_w1c_bank #(.WIDTH(DATA_W), .MASK(LATCH_MASK1)) u_flags1 (
        .clk(clk), .rst_n(rst_n), .set_i(set1), .clr_i(clr1), .q(flags1));

    ish_rw_reg #(.WIDTH(DATA_W)) u_en0 (
        .clk(clk), .rst_n(rst_n), .we(wr2), .wdata(reg_wdata), .q(en0_q));

    ish_rw_reg #(.WIDTH(DATA_W)) u_en1 (
        .clk(clk), .rst_n(rst_n), .we(wr3), .wdata(reg_wdata), .q(en1_q));

    // Status 0 view: latched flags plus live endpoint levels
    always_comb begin
        view0 = flags0;
        view0[EP_N-1:0] = ep_pending;
    end

    ish_irq_combine #(.WIDTH(DATA_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .stat0(view0), .stat1(flags1),
        .en0(en0_q), .en1(en1_q), .irq(irq_out));

    // One-cycle suspend entry on write-1 to the suspend flag
    always_ff @(posedge clk) begin
        if (!rst_n) susp_q <= 1'b0;
        else        susp_q <= wr1 && reg_wdata[SUSP_BIT];
    end
    assign suspend_enter = susp_q;

    // Combinational read mux
    always_comb begin
        unique case (reg_addr)
            OFS_STAT0: reg_rdata = view0;
            OFS_STAT1: reg_rdata = flags1;
            OFS_EN0:   reg_rdata = en0_q;
            default:   reg_rdata = en1_q;
        endcase
    end

    p_susp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_STAT1 && reg_wdata[SUSP_BIT]) |=> suspend_enter);
    p_susp_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == OFS_STAT1 && reg_wdata[SUSP_BIT]) |=> !suspend_enter);
    p_unused_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr == OFS_STAT0) |-> !reg_rdata[4]) and
        ((reg_addr == OFS_STAT1) |-> !reg_rdata[0]));
    p_ep_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_STAT0) |-> (reg_rdata[EP_N-1:0] == ep_pending));
endmodule

// File: tb/sim_irq_status_hub.sv
`timescale 1ns/1ps
module sim_irq_status_hub;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic       sof_pulse = 1'b0;
    logic [1:0] evt0_pulse = '0;
    logic [5:0] evt1_pulse = '0;
    logic       suspend_req = 1'b0;
    logic [3:0] ep_pending = '0;
    logic       irq_out, suspend_enter;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_s0 = '0, m_s1 = '0, m_en0 = '0, m_en1 = '0;
    logic exp_irq = 1'b0, exp_susp = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_hub u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .sof_pulse(sof_pulse),
        .evt0_pulse(evt0_pulse), .evt1_pulse(evt1_pulse),
        .suspend_req(suspend_req), .ep_pending(ep_pending),
        .irq_out(irq_out), .suspend_enter(suspend_enter));

    function automatic logic [7:0] view0();
        return m_s0 | {4'b0, ep_pending};
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return view0();
            2'd1:    return m_s1;
            2'd2:    return m_en0;
            default: return m_en1;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [1:0] a, input string tag);
        reg_addr = a;
        #0.5;
        check(tag, reg_rdata, exp_read(a));
    endtask

    // One clock: update model, step, check irq and suspend, clear pulses
    task automatic cyc();
        logic [7:0] s0set, s1set, c0, c1;
        exp_irq  = |(view0() & m_en0) || |(m_s1 & m_en1);
        exp_susp = reg_we && reg_addr == 2'd1 && reg_wdata[3];
        s0set = {sof_pulse, evt0_pulse, 5'b0};
        s1set = {evt1_pulse[5:2], suspend_req, evt1_pulse[1:0], 1'b0};
        c0 = (reg_we && reg_addr == 2'd0) ? reg_wdata : 8'h0;
        c1 = (reg_we && reg_addr == 2'd1) ? reg_wdata : 8'h0;
        m_s0 = ((m_s0 & ~c0) | s0set) & 8'hE0;
        m_s1 = ((m_s1 & ~c1) | s1set) & 8'hFE;
        if (reg_we && reg_addr == 2'd2) m_en0 = reg_wdata;
        if (reg_we && reg_addr == 2'd3) m_en1 = reg_wdata;
        @(posedge clk);
        #1;
        check("R10 irq_out", {7'b0, irq_out}, {7'b0, exp_irq});
        check("R5 suspend_enter", {7'b0, suspend_enter}, {7'b0, exp_susp});
        @(negedge clk);
        reg_we = 1'b0; sof_pulse = 1'b0; evt0_pulse = '0;
        evt1_pulse = '0; suspend_req = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        cyc();
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R1 reset state
        check("R1 irq_out", {7'b0, irq_out}, 8'h0);
        check("R1 suspend_enter", {7'b0, suspend_enter}, 8'h0);
        for (int a = 0; a < 4; a++) rd_chk(a[1:0], "R1 reset read");
        @(negedge clk);
        // R2 mirror and write immunity
        ep_pending = 4'b1010;
        rd_chk(2'd0, "R2 mirror");
        wr(2'd0, 8'h0F);
        rd_chk(2'd0, "R2 write ignored");
        ep_pending = 4'b0000;
        rd_chk(2'd0, "R2 follows level");
        // R3 and R6 sof latches with enables zero
        sof_pulse = 1'b1; cyc();
        rd_chk(2'd0, "R3 sof set");
        cyc();
        check("R6 no irq when disabled", {7'b0, irq_out}, 8'h0);
        wr(2'd0, 8'h80);
        rd_chk(2'd0, "R3 sof cleared");
        // R4 lanes and write-0 retention
        evt1_pulse = 6'h3F; evt0_pulse = 2'b11; cyc();
        rd_chk(2'd1, "R4 stat1 lanes");
        rd_chk(2'd0, "R4 stat0 lanes");
        wr(2'd1, 8'h06);
        rd_chk(2'd1, "R4 partial clear");
        wr(2'd1, 8'hF0);
        wr(2'd0, 8'h60);
        // R5 suspend flag and pulse
        suspend_req = 1'b1; cyc();
        rd_chk(2'd1, "R5 flag set");
        wr(2'd1, 8'h08);
        rd_chk(2'd1, "R5 flag cleared");
        cyc();
        // R7 unused bits
        wr(2'd0, 8'h10); wr(2'd1, 8'h01);
        reg_addr = 2'd0; #0.5; check("R7 stat0 bit4", {7'b0, reg_rdata[4]}, 8'h0);
        reg_addr = 2'd1; #0.5; check("R7 stat1 bit0", {7'b0, reg_rdata[0]}, 8'h0);
        // R8 set wins over same-cycle clear
        sof_pulse = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h80; reg_we = 1'b1; cyc();
        rd_chk(2'd0, "R8 set wins");
        wr(2'd0, 8'h80);
        // R9 enables
        wr(2'd2, 8'hA5); rd_chk(2'd2, "R9 en0");
        wr(2'd3, 8'h5A); rd_chk(2'd3, "R9 en1");
        wr(2'd2, 8'h00); wr(2'd3, 8'h00);
        // R10 latency: flag set, irq one edge later
        wr(2'd2, 8'h80);
        sof_pulse = 1'b1; cyc();
        cyc();
        wr(2'd0, 8'h80); cyc();
        // R11 random mix
        for (int k = 0; k < 3000; k++) begin
            sof_pulse   = ($urandom % 5) == 0;
            evt0_pulse  = 2'($urandom) & 2'($urandom);
            evt1_pulse  = 6'($urandom) & 6'($urandom) & 6'($urandom);
            suspend_req = ($urandom % 6) == 0;
            if (($urandom % 4) == 0) ep_pending = 4'($urandom);
            reg_addr  = 2'($urandom);
            reg_wdata = 8'($urandom);
            reg_we    = ($urandom % 3) == 0;
            #0.5;
            check("R11 random read", reg_rdata, exp_read(reg_addr));
            cyc();
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule